// File: doc/BRIEF.md
# Time-Slot MAC Timer

This block keeps time for a slotted radio MAC protocol. A free-running counter counts clock cycles from zero up to a programmed period and then returns to zero. Each return to zero advances a small overflow counter, so software can track elapsed periods as well as the position inside the current period. An overflow-compare register raises an interrupt flag when the overflow counter reaches a chosen value, which lets software set up long timeouts.

Two hardware assists sit on top of the counter. The first is a capture register. It records the counter value when a frame event reaches the block: either the frame-delimiter event or the end-of-transmission event, chosen by a control bit. The captured value then stays frozen until software clears the capture flag. The second is an armed compare. When the counter equals the compare value, the block emits one single-cycle strobe on the radio command line selected by a command code, then disarms itself.

Software talks to the block over a simple byte-wide register port. A read of the counter's low byte also freezes the high byte and the overflow count in shadow registers, so a read of several bytes gives one consistent snapshot.

Top module: `slot_timer`

## Requirements
- R1: After reset the counter, overflow counter, all flags, all strobes, the command armed bit and the run bit are zero, and the period register is zero.
- R2: While the run bit (control register 0xB, bit 0) is set, the counter steps by one each cycle from 0 up to period−1 and then returns to 0. A period of 0 gives a full 2^CNT_W-cycle period. A counter at or above period−1 also returns to 0. While the run bit is clear, the counter holds its value.
- R3: The overflow counter increments in the cycle in which the counter returns to 0. It wraps from 255 to 0.
- R4: A read of address 0x0 returns the counter low byte on rdata in the next cycle. The same read latches the counter high byte and the overflow count, and later reads of 0x1 and 0x2 return those latched values. Each read's data appears one cycle after rd_en, and rdata holds it until the next read.
- R5: Control register bit 1 selects the capture source: 0 selects sfd_evt, 1 selects tx_end_evt. A pulse on the selected input copies the counter into the capture register (read at 0x5/0x6) and sets the capture flag (flags register 0xC bit 0, driven on irq_cap). A pulse on the unselected input has no effect.
- R6: While the capture flag is set, further capture events leave the capture register unchanged. Writing 1 to a flag bit at 0xC clears that flag. A flag set in the same cycle wins over a clear.
- R7: Writing 0x9 with bit 7 set arms the compare, with bits 2:0 as the command code. While armed and running, a counter equal to the compare register (0x7/0x8) pulses strobe bit [code] for exactly one cycle, starting one cycle later. The same match clears the armed bit (read back at 0x9 bit 7) and sets the compare flag (0xC bit 1, driven on irq_cmp). At most one strobe bit is high at a time.
- R8: An armed compare fires only once. Later passes of the counter through the compare value produce no strobe until software arms it again.
- R9: When a period wrap brings the overflow counter to the value in the overflow-compare register (0xA), the overflow flag (0xC bit 2, driven on irq_ovf) is set.
- R10: The period (0x3/0x4), compare (0x7/0x8), command (0x9), overflow-compare (0xA) and control (0xB) registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| sfd_evt | input | 1 | Frame-delimiter event pulse |
| tx_end_evt | input | 1 | End-of-transmission event pulse |
| strobe | output | 2^CMD_W | One-hot radio command strobes |
| irq_cap | output | 1 | Capture flag |
| irq_cmp | output | 1 | Compare-fired flag |
| irq_ovf | output | 1 | Overflow-compare flag |

## Verification
The bench builds the block with its defaults: a 16-bit counter, an 8-bit overflow counter and a 3-bit command code giving eight strobe lines. Because the period is programmable, short periods of 1 and 10 cycles bring the 255-to-0 overflow wrap and the overflow-compare match within a few hundred cycles. A period of 0 runs one full 65,536-cycle period, so the high counter byte passes through nonzero values and the shadowed read of R4 is exercised.

// File: rtl/slot_timer_pkg.sv
package slot_timer_pkg;
    localparam int BUS_W  = 8;
    localparam int ADDR_W = 4;
    localparam int FLG_N  = 3;

    localparam logic [ADDR_W-1:0] A_CNT_LO = 4'h0;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 4'h1;
    localparam logic [ADDR_W-1:0] A_OVF    = 4'h2;
    localparam logic [ADDR_W-1:0] A_PER_LO = 4'h3;
    localparam logic [ADDR_W-1:0] A_PER_HI = 4'h4;
    localparam logic [ADDR_W-1:0] A_CAP_LO = 4'h5;
    localparam logic [ADDR_W-1:0] A_CAP_HI = 4'h6;
    localparam logic [ADDR_W-1:0] A_CMP_LO = 4'h7;
    localparam logic [ADDR_W-1:0] A_CMP_HI = 4'h8;
    localparam logic [ADDR_W-1:0] A_CMD    = 4'h9;
    localparam logic [ADDR_W-1:0] A_OVFCMP = 4'hA;
    localparam logic [ADDR_W-1:0] A_CTRL   = 4'hB;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 4'hC;

    localparam int FLG_CAP = 0;
    localparam int FLG_CMP = 1;
    localparam int FLG_OVF = 2;
endpackage

// File: rtl/slot_timer_count.sv
module slot_timer_count #(
    parameter int CNT_W = 16,
    parameter int OVF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] period,
    input  logic [OVF_W-1:0] ovf_cmp,
    output logic [CNT_W-1:0] cnt,
    output logic [OVF_W-1:0] ovf,
    output logic             ovf_hit
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [OVF_W-1:0] ovf;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    logic [CNT_W-1:0] last;
    logic [OVF_W-1:0] ovf_inc;
    logic             wrap;

    always_comb begin
        st_d    = st_q;
        last    = (period == '0) ? '1 : period - CNT_W'(1);
        wrap    = run && (st_q.cnt >= last);
        ovf_inc = st_q.ovf + OVF_W'(1);
        ovf_hit = wrap && (ovf_inc == ovf_cmp);
        if (run) begin
            if (wrap) begin
                st_d.cnt = '0;
                st_d.ovf = ovf_inc;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign ovf = st_q.ovf;
endmodule

// File: rtl/slot_timer_capture.sv
module slot_timer_capture #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sfd_evt,
    input  logic             tx_end_evt,
    input  logic             sel_txend,
    input  logic             hold,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap,
    output logic             cap_set
);
    typedef struct packed {
        logic [CNT_W-1:0] cap;
    } cap_st_t;

    cap_st_t st_d, st_q;
    logic    evt;

    always_comb begin
        st_d    = st_q;
        evt     = sel_txend ? tx_end_evt : sfd_evt;
        cap_set = evt && !hold;
        if (cap_set) st_d.cap = cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap = st_q.cap;
endmodule

// File: rtl/slot_timer_strobe.sv
module slot_timer_strobe #(
    parameter int CNT_W = 16,
    parameter int CMD_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               armed,
    input  logic [CMD_W-1:0]   code,
    input  logic [CNT_W-1:0]   cnt,
    input  logic [CNT_W-1:0]   cmp,
    output logic               fire,
    output logic [(1<<CMD_W)-1:0] strobe
);
    localparam int N_STR = 1 << CMD_W;

    logic [N_STR-1:0] str_d, str_q;

    assign fire = armed && run && (cnt == cmp);

    for (genvar g = 0; g < N_STR; g++) begin : g_line
        assign str_d[g] = fire && (code == CMD_W'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) str_q <= '0;
        else        str_q <= str_d;
    end

    assign strobe = str_q;
endmodule

// File: rtl/slot_timer_regs.sv
module slot_timer_regs
    import slot_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int OVF_W = 8,
    parameter int CMD_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [OVF_W-1:0]  ovf,
    input  logic [CNT_W-1:0]  cap,
    input  logic              fire,
    input  logic              cap_set,
    input  logic              ovf_hit,
    output logic [CNT_W-1:0]  period,
    output logic [CNT_W-1:0]  cmp,
    output logic [CMD_W-1:0]  code,
    output logic              armed,
    output logic [OVF_W-1:0]  ovf_cmp,
    output logic              run,
    output logic              sel_txend,
    output logic [FLG_N-1:0]  flags
);
    typedef struct packed {
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] cmp;
        logic [CMD_W-1:0] code;
        logic             armed;
        logic [OVF_W-1:0] ovfcmp;
        logic             run;
        logic             sel;
        logic [FLG_N-1:0] flags;
        logic [BUS_W-1:0] sh_hi;
        logic [OVF_W-1:0] sh_ovf;
        logic [BUS_W-1:0] rdata;
    } regs_st_t;

    regs_st_t    st_d, st_q;
    logic [15:0] per16, cmp16, cnt16, cap16;
    logic [15:0] per_wlo, per_whi, cmp_wlo, cmp_whi;
    logic [7:0]  cmd_rd, ctrl_rd, flg_rd;

    assign per16   = 16'(st_q.per);
    assign cmp16   = 16'(st_q.cmp);
    assign cnt16   = 16'(cnt);
    assign cap16   = 16'(cap);
    assign per_wlo = {per16[15:8], wdata};
    assign per_whi = {wdata, per16[7:0]};
    assign cmp_wlo = {cmp16[15:8], wdata};
    assign cmp_whi = {wdata, cmp16[7:0]};

    always_comb begin
        cmd_rd                 = '0;
        cmd_rd[7]              = st_q.armed;
        cmd_rd[CMD_W-1:0]      = st_q.code;
        ctrl_rd                = {6'd0, st_q.sel, st_q.run};
        flg_rd                 = '0;
        flg_rd[FLG_N-1:0]      = st_q.flags;
    end

    always_comb begin
        st_d = st_q;

        // software clears flags, hardware set wins below
        if (wr_en && addr == A_FLAGS)
            st_d.flags = st_q.flags & ~wdata[FLG_N-1:0];

        // a compare match disarms, a write in the same cycle overrides
        if (fire) st_d.armed = 1'b0;

        if (wr_en) begin
            case (addr)
                A_PER_LO: st_d.per    = per_wlo[CNT_W-1:0];
                A_PER_HI: st_d.per    = per_whi[CNT_W-1:0];
                A_CMP_LO: st_d.cmp    = cmp_wlo[CNT_W-1:0];
                A_CMP_HI: st_d.cmp    = cmp_whi[CNT_W-1:0];
                A_CMD: begin
                    st_d.code  = wdata[CMD_W-1:0];
                    st_d.armed = wdata[7];
                end
                A_OVFCMP: st_d.ovfcmp = wdata[OVF_W-1:0];
                A_CTRL: begin
                    st_d.run = wdata[0];
                    st_d.sel = wdata[1];
                end
                default: ;
            endcase
        end

        st_d.flags[FLG_CAP] = st_d.flags[FLG_CAP] | cap_set;
        st_d.flags[FLG_CMP] = st_d.flags[FLG_CMP] | fire;
        st_d.flags[FLG_OVF] = st_d.flags[FLG_OVF] | ovf_hit;

        if (rd_en) begin
            case (addr)
                A_CNT_LO: begin
                    st_d.rdata  = cnt16[7:0];
                    st_d.sh_hi  = cnt16[15:8];
                    st_d.sh_ovf = ovf;
                end
                A_CNT_HI: st_d.rdata = st_q.sh_hi;
                A_OVF:    st_d.rdata = BUS_W'(st_q.sh_ovf);
                A_PER_LO: st_d.rdata = per16[7:0];
                A_PER_HI: st_d.rdata = per16[15:8];
                A_CAP_LO: st_d.rdata = cap16[7:0];
                A_CAP_HI: st_d.rdata = cap16[15:8];
                A_CMP_LO: st_d.rdata = cmp16[7:0];
                A_CMP_HI: st_d.rdata = cmp16[15:8];
                A_CMD:    st_d.rdata = cmd_rd;
                A_OVFCMP: st_d.rdata = BUS_W'(st_q.ovfcmp);
                A_CTRL:   st_d.rdata = ctrl_rd;
                A_FLAGS:  st_d.rdata = flg_rd;
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata     = st_q.rdata;
    assign period    = st_q.per;
    assign cmp       = st_q.cmp;
    assign code      = st_q.code;
    assign armed     = st_q.armed;
    assign ovf_cmp   = st_q.ovfcmp;
    assign run       = st_q.run;
    assign sel_txend = st_q.sel;
    assign flags     = st_q.flags;
endmodule

// File: rtl/slot_timer.sv
module slot_timer
    import slot_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int OVF_W = 8,
    parameter int CMD_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [3:0]            addr,
    input  logic [7:0]            wdata,
    output logic [7:0]            rdata,
    input  logic                  sfd_evt,
    input  logic                  tx_end_evt,
    output logic [(1<<CMD_W)-1:0] strobe,
    output logic                  irq_cap,
    output logic                  irq_cmp,
    output logic                  irq_ovf
);
    logic [CNT_W-1:0] cnt_w, per_w, cmp_w, cap_w;
    logic [OVF_W-1:0] ovf_w, ovfcmp_w;
    logic [CMD_W-1:0] code_w;
    logic [FLG_N-1:0] flags_w;
    logic             run_w, sel_w, armed_w, fire_w, cap_set_w, ovf_hit_w;

    slot_timer_regs #(.CNT_W(CNT_W), .OVF_W(OVF_W), .CMD_W(CMD_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .cnt(cnt_w), .ovf(ovf_w), .cap(cap_w),
        .fire(fire_w), .cap_set(cap_set_w), .ovf_hit(ovf_hit_w),
        .period(per_w), .cmp(cmp_w), .code(code_w), .armed(armed_w),
        .ovf_cmp(ovfcmp_w), .run(run_w), .sel_txend(sel_w), .flags(flags_w)
    );

    slot_timer_count #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_count (
        .clk(clk), .rst_n(rst_n), .run(run_w), .period(per_w),
        .ovf_cmp(ovfcmp_w), .cnt(cnt_w), .ovf(ovf_w), .ovf_hit(ovf_hit_w)
    );

    slot_timer_capture #(.CNT_W(CNT_W)) u_capture (
        .clk(clk), .rst_n(rst_n), .sfd_evt(sfd_evt), .tx_end_evt(tx_end_evt),
        .sel_txend(sel_w), .hold(flags_w[FLG_CAP]), .cnt(cnt_w),
        .cap(cap_w), .cap_set(cap_set_w)
    );

    slot_timer_strobe #(.CNT_W(CNT_W), .CMD_W(CMD_W)) u_strobe (
        .clk(clk), .rst_n(rst_n), .run(run_w), .armed(armed_w),
        .code(code_w), .cnt(cnt_w), .cmp(cmp_w),
        .fire(fire_w), .strobe(strobe)
    );

    assign irq_cap = flags_w[FLG_CAP];
    assign irq_cmp = flags_w[FLG_CMP];
    assign irq_ovf = flags_w[FLG_OVF];
endmodule

// File: rtl/slot_timer_chk.sv
module slot_timer_chk #(
    parameter int CNT_W = 16,
    parameter int OVF_W = 8,
    parameter int CMD_W = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [CNT_W-1:0]      cnt,
    input logic [OVF_W-1:0]      ovf,
    input logic [CNT_W-1:0]      period,
    input logic                  run,
    input logic [CNT_W-1:0]      cap,
    input logic [(1<<CMD_W)-1:0] strobe,
    input logic                  irq_cap,
    input logic                  irq_cmp
);
    // R2
    period_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period != '0 && period == $past(period) && $past(run)) |-> (cnt < period));

    // R2
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> (cnt == $past(cnt)));

    // R3
    ovf_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf != $past(ovf)) |-> (cnt == '0 && ovf == OVF_W'($past(ovf) + 1'b1)));

    // R6
    cap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_cap) && irq_cap) |-> $stable(cap));

    // R7
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobe));

    // R7
    strobe_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe != '0) |-> irq_cmp);
endmodule

bind slot_timer slot_timer_chk #(.CNT_W(CNT_W), .OVF_W(OVF_W), .CMD_W(CMD_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .cnt(cnt_w), .ovf(ovf_w), .period(per_w),
    .run(run_w), .cap(cap_w), .strobe(strobe), .irq_cap(irq_cap), .irq_cmp(irq_cmp)
);

// File: tb/test_slot_timer.sv
module test_slot_timer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       sfd_evt = 1'b0, tx_end_evt = 1'b0;
    logic [7:0] strobe;
    logic       irq_cap, irq_cmp, irq_ovf;

    int n_chk = 0, n_fail = 0, n_strobes = 0;
    bit done = 0;

    slot_timer i_slot_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .sfd_evt(sfd_evt), .tx_end_evt(tx_end_evt),
        .strobe(strobe), .irq_cap(irq_cap), .irq_cmp(irq_cmp), .irq_ovf(irq_ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    int m_cnt, m_ovf, m_per, m_cmp, m_code, m_ovfcmp, m_cap, m_rdata, m_shi, m_sovf, m_strobe;
    bit m_armed, m_run, m_sel, m_fcap, m_fcmp, m_fovf;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_ovf = 0; m_per = 0; m_cmp = 0; m_code = 0; m_ovfcmp = 0;
            m_cap = 0; m_rdata = 0; m_shi = 0; m_sovf = 0; m_strobe = 0;
            m_armed = 0; m_run = 0; m_sel = 0; m_fcap = 0; m_fcmp = 0; m_fovf = 0;
        end else begin
            int lim, ncnt, novf;
            bit wrap, fire, ev, hit;
            lim  = (m_per == 0) ? 65536 : m_per;
            wrap = m_run && (m_cnt >= lim - 1);
            fire = m_armed && m_run && (m_cnt == m_cmp);
            ev   = m_sel ? tx_end_evt : sfd_evt;
            ncnt = m_run ? (wrap ? 0 : m_cnt + 1) : m_cnt;
            novf = wrap ? (m_ovf + 1) % 256 : m_ovf;
            hit  = wrap && (novf == m_ovfcmp);
            if (rd_en) begin
                case (addr)
                    4'h0: begin m_rdata = m_cnt % 256; m_shi = m_cnt / 256; m_sovf = m_ovf; end
                    4'h1: m_rdata = m_shi;
                    4'h2: m_rdata = m_sovf;
                    4'h3: m_rdata = m_per % 256;
                    4'h4: m_rdata = m_per / 256;
                    4'h5: m_rdata = m_cap % 256;
                    4'h6: m_rdata = m_cap / 256;
                    4'h7: m_rdata = m_cmp % 256;
                    4'h8: m_rdata = m_cmp / 256;
                    4'h9: m_rdata = (m_armed ? 128 : 0) + m_code;
                    4'hA: m_rdata = m_ovfcmp;
                    4'hB: m_rdata = (m_sel ? 2 : 0) + (m_run ? 1 : 0);
                    4'hC: m_rdata = (m_fovf ? 4 : 0) + (m_fcmp ? 2 : 0) + (m_fcap ? 1 : 0);
                    default: m_rdata = 0;
                endcase
            end
            m_strobe = fire ? (1 << m_code) : 0;
            if (ev && !m_fcap) m_cap = m_cnt;
            if (wr_en && addr == 4'hC) begin
                if (wdata[0]) m_fcap = 0;
                if (wdata[1]) m_fcmp = 0;
                if (wdata[2]) m_fovf = 0;
            end
            if (ev && !m_cap_hold_dummy()) ;
            if (fire) m_armed = 0;
            if (wr_en) begin
                case (addr)
                    4'h3: m_per = (m_per / 256) * 256 + wdata;
                    4'h4: m_per = wdata * 256 + m_per % 256;
                    4'h7: m_cmp = (m_cmp / 256) * 256 + wdata;
                    4'h8: m_cmp = wdata * 256 + m_cmp % 256;
                    4'h9: begin m_code = wdata[2:0]; m_armed = wdata[7]; end
                    4'hA: m_ovfcmp = wdata;
                    4'hB: begin m_run = wdata[0]; m_sel = wdata[1]; end
                    default: ;
                endcase
            end
            m_fcap = m_fcap | (ev && !cap_was_held);
            m_fcmp = m_fcmp | fire;
            m_fovf = m_fovf | hit;
            m_cnt = ncnt;
            m_ovf = novf;
        end
    end

    // capture-flag state before this edge, kept for the set term above
    bit cap_was_held;
    always @(negedge clk) cap_was_held = m_fcap;
    function automatic bit m_cap_hold_dummy();
        return 1'b0;
    endfunction

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R7", "strobe", int'(strobe), m_strobe);
            chk("R5", "irq_cap", int'(irq_cap), int'(m_fcap));
            chk("R7", "irq_cmp", int'(irq_cmp), int'(m_fcmp));
            chk("R9", "irq_ovf", int'(irq_ovf), int'(m_fovf));
            chk("R4", "rdata", int'(rdata), m_rdata);
            if (strobe != 0) n_strobes++;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; v = int'(rdata);
    endtask

    task automatic pulse(input bit txe);
        @(negedge clk); if (txe) tx_end_evt = 1'b1; else sfd_evt = 1'b1;
        @(negedge clk); tx_end_evt = 1'b0; sfd_evt = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1;
        summary();
        $finish;
    end

    initial begin
        int v, a, b, c0;
        idle(3);
        // R1 reset state
        chk("R1", "strobe in reset", int'(strobe), 0);
        chk("R1", "flags in reset", int'({irq_cap, irq_cmp, irq_ovf}), 0);
        rst_n = 1'b1;
        rd(4'h0, v); chk("R1", "counter after reset", v, 0);
        rd(4'hC, v); chk("R1", "flags reg after reset", v, 0);
        rd(4'h9, v); chk("R1", "command reg after reset", v, 0);

        // R10 config readback
        wr(4'h3, 8'd10);
        wr(4'hA, 8'd3);
        rd(4'h3, v); chk("R10", "period low", v, 10);
        rd(4'hA, v); chk("R10", "overflow compare", v, 3);

        // R2 R3 R9 short period
        wr(4'hB, 8'h01);
        idle(45);
        chk("R9", "overflow compare flag", int'(irq_ovf), 1);
        rd(4'h0, v); chk("R2", "counter below period", int'(v < 10), 1);
        rd(4'h2, v); chk("R3", "overflow count", v, m_sovf);
        wr(4'hC, 8'h07);
        idle(1);
        chk("R6", "flag cleared by write", int'(irq_ovf), 0);

        // R7 R8 compare strobe
        wr(4'h7, 8'd4);
        wr(4'h8, 8'd0);
        rd(4'h7, v); chk("R10", "compare low", v, 4);
        n_strobes = 0;
        wr(4'h9, 8'h85);
        idle(40);
        chk("R8", "strobes per arming", n_strobes, 1);
        chk("R7", "compare flag", int'(irq_cmp), 1);
        rd(4'h9, v); chk("R7", "armed bit cleared", v, 5);

        // R5 R6 capture
        pulse(1'b0);
        chk("R5", "capture flag on sfd", int'(irq_cap), 1);
        rd(4'h5, a); chk("R5", "captured low byte", a, m_cap % 256);
        idle(3);
        pulse(1'b0);
        rd(4'h5, b); chk("R6", "capture held while flag set", b, a);
        wr(4'hC, 8'h01);
        wr(4'hB, 8'h03);
        rd(4'hB, v); chk("R10", "control readback", v, 3);
        pulse(1'b0);
        idle(1);
        chk("R5", "unselected event ignored", int'(irq_cap), 0);
        pulse(1'b1);
        chk("R5", "capture on end of tx", int'(irq_cap), 1);
        rd(4'h5, v); chk("R5", "tx-end capture value", v, m_cap % 256);

        // R2 hold when stopped
        wr(4'hB, 8'h00);
        rd(4'h0, a);
        idle(5);
        rd(4'h0, b);
        chk("R2", "counter holds when stopped", b, a);

        // R3 overflow wrap 255 -> 0 with period 1
        wr(4'h3, 8'd1);
        wr(4'hB, 8'h01);
        idle(300);
        wr(4'hB, 8'h00);
        rd(4'h0, v);
        rd(4'h2, v); chk("R3", "overflow after wrap", v, m_ovf);

        // R2 R4 full period with period 0
        wr(4'hC, 8'h07);
        wr(4'h3, 8'd0);
        rd(4'h2, c0);
        wr(4'hB, 8'h01);
        idle(40000);
        rd(4'h0, v);
        rd(4'h1, a); chk("R4", "shadow high byte", a, m_shi);
        chk("R4", "high byte nonzero mid-period", int'(a != 0), 1);
        rd(4'h2, b); chk("R4", "shadow overflow", b, c0);
        idle(26000);
        rd(4'h0, v);
        rd(4'h2, b); chk("R2", "full period wrapped once", b, (c0 + 1) % 256);

        idle(2);
        done = 1;
        summary();
        $finish;
    end
endmodule